// File: doc/BRIEF.md
# Serial Flag Offset Loader

This block keeps the two threshold values that a FIFO's almost-empty and almost-full comparators use. Both values are loaded through one serial data pin, one bit per rising edge of the write clock, while an active-low load enable and an active-low serial enable are both asserted. The two offsets form a single stream of twice the offset width. It starts at bit 0 of the almost-empty offset, continues through that offset's top bit, then runs from bit 0 to the top bit of the almost-full offset.

The stream can be paused at any bit by releasing either enable. During such a pause the surrounding FIFO may carry out ordinary writes. When both enables return low, loading resumes at the next bit in order. A load can only replace both offsets together. As soon as the first bit of a new set is captured, both per-flag valid outputs drop. They stay low until the last bit has arrived and a configurable number of further clock edges have passed, so the comparators ignore half-written thresholds. A one-cycle ready pulse marks the completion of each full set. Master reset restores default offsets and marks both flags valid.

Top module: `serial_offset_loader`

## Requirements
- R1: While `rst_n` is low and after its release, `ae_ofs` equals `DEF_AE`, `af_ofs` equals `DEF_AF`, `ae_valid` and `af_valid` are 1, and `set_done` is 0.
- R2: A bit is captured on a rising `clk` edge only when `load_n` and `sen_n` are both 0, and exactly one bit is captured on each such edge.
- R3: Stream bit k (k counted from 0 since reset or since the previous complete set) is written to `ae_ofs[k]` for k < OFS_W and to `af_ofs[k-OFS_W]` otherwise. It is visible on the output after the capturing edge.
- R4: On an edge where `load_n` is 0 and `sen_n` is 1, or `load_n` is 1, nothing is captured and both offset outputs keep their values whatever `sdi` carries.
- R5: After a pause of any length, the next edge with both enables low captures the stream bit that follows the last one captured.
- R6: The edge that captures stream bit 0 clears both `ae_valid` and `af_valid`, and both stay 0 until the set is complete.
- R7: `set_done` is 1 for exactly the one cycle that follows the edge capturing the last stream bit (bit 2*OFS_W-1).
- R8: `af_valid` rises at the `AF_DLY`-th rising edge after the final capture edge, and `ae_valid` rises at the `AE_DLY`-th edge (both 2 by default).
- R9: After a complete set, the bit position wraps to 0, so a following load rewrites both offsets starting again at `ae_ofs[0]`.
- R10: A master reset in the middle of a load restores the defaults and valid flags, and the next load starts at stream bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| load_n | input | 1 | Offset load enable, active low |
| sen_n | input | 1 | Serial shift enable, active low |
| sdi | input | 1 | Serial offset data |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| ae_valid | output | 1 | Almost-empty flag may be trusted |
| af_valid | output | 1 | Almost-full flag may be trusted |
| set_done | output | 1 | One-cycle pulse after a complete offset set |

## Verification
The offsets are loaded with streams whose two halves differ and whose bits alternate irregularly. A bit landing in the wrong position or the wrong register therefore shows up as a wrong value. A second load with different contents shows that the bit position wraps correctly. Loads are also paused in each of the three non-shifting enable combinations, with `sdi` driven to the opposite of the next bit. This distinguishes a design that honours only one of the enables, or one that skips or repeats a bit on resume. Around each completion, the ready pulse and the two valid outputs are sampled cycle by cycle, which separates a correct latency from one that is an edge early or late. A reset in the middle of a load shows that the partial state is discarded.

// File: rtl/ofsl_pkg.sv
package ofsl_pkg;

   // Width needed to index every bit of the combined offset stream.
   function automatic int stream_idx_w(input int ofs_w);
      int total;
      total = 2 * ofs_w;
      return (total < 2) ? 1 : $clog2(total);
   endfunction

endpackage

// File: rtl/ofsl_bitpos.sv
// Stream position counter: advances once per captured bit, wraps after the last.
module ofsl_bitpos #(
   parameter int OFS_W = 10,
   localparam int TOTAL = 2 * OFS_W,
   localparam int IDX_W = ofsl_pkg::stream_idx_w(OFS_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   output logic [IDX_W-1:0] pos,
   output logic             at_first,
   output logic             at_last,
   output logic             done_pulse
);

   localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(TOTAL - 1);

   assign at_first = (pos == '0);
   assign at_last  = (pos == LAST_POS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos        <= '0;
         done_pulse <= 1'b0;
      end else begin
         done_pulse <= shift && at_last;
         if (shift) begin
            pos <= at_last ? '0 : pos + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ofsl_store.sv
// Offset storage: one flop per stream bit, each written only at its own position.
module ofsl_store #(
   parameter int OFS_W = 10,
   parameter logic [OFS_W-1:0] DEF_AE = '0,
   parameter logic [OFS_W-1:0] DEF_AF = '0,
   localparam int TOTAL = 2 * OFS_W,
   localparam int IDX_W = ofsl_pkg::stream_idx_w(OFS_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic [IDX_W-1:0] pos,
   input  logic             din,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs
);

   localparam logic [TOTAL-1:0] DEF_ALL = {DEF_AF, DEF_AE};

   logic [TOTAL-1:0] bits_q;

   for (genvar gi = 0; gi < TOTAL; gi++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bits_q[gi] <= DEF_ALL[gi];
         end else if (shift && (pos == IDX_W'(gi))) begin
            bits_q[gi] <= din;
         end
      end
   end

   assign ae_ofs = bits_q[OFS_W-1:0];
   assign af_ofs = bits_q[TOTAL-1:OFS_W];

endmodule

// File: rtl/ofsl_validgen.sv
// Per-flag validity: cleared at the start of a set, raised DLY edges after its end.
module ofsl_validgen #(
   parameter int DLY = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fin,
   output logic valid
);

   logic [DLY-1:0] stg_q;

   if (DLY == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     stg_q <= '0;
         else if (start) stg_q <= '0;
         else            stg_q <= fin;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     stg_q <= '0;
         else if (start) stg_q <= '0;
         else            stg_q <= {stg_q[DLY-2:0], fin};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 valid <= 1'b1;
      else if (start)             valid <= 1'b0;
      else if (stg_q[DLY-1])      valid <= 1'b1;
   end

endmodule

// File: rtl/serial_offset_loader.sv
module serial_offset_loader #(
   parameter int OFS_W = 10,
   parameter logic [OFS_W-1:0] DEF_AE = OFS_W'(8),
   parameter logic [OFS_W-1:0] DEF_AF = OFS_W'(16),
   parameter int AE_DLY = 2,
   parameter int AF_DLY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_n,
   input  logic             sen_n,
   input  logic             sdi,
   output logic [OFS_W-1:0] ae_ofs,
   output logic [OFS_W-1:0] af_ofs,
   output logic             ae_valid,
   output logic             af_valid,
   output logic             set_done
);

   localparam int IDX_W = ofsl_pkg::stream_idx_w(OFS_W);

   if (OFS_W < 1) begin : g_bad_w
      $error("serial_offset_loader: OFS_W must be at least 1");
   end
   if (AE_DLY < 1 || AF_DLY < 1) begin : g_bad_dly
      $error("serial_offset_loader: flag delays must be at least 1");
   end

   logic             shift;
   logic [IDX_W-1:0] pos;
   logic             at_first;
   logic             at_last;

   assign shift = !load_n && !sen_n;

   ofsl_bitpos #(.OFS_W(OFS_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .shift(shift), .pos(pos),
      .at_first(at_first), .at_last(at_last), .done_pulse(set_done)
   );

   ofsl_store #(.OFS_W(OFS_W), .DEF_AE(DEF_AE), .DEF_AF(DEF_AF)) u_store (
      .clk(clk), .rst_n(rst_n), .shift(shift), .pos(pos), .din(sdi),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs)
   );

   ofsl_validgen #(.DLY(AE_DLY)) u_ae_v (
      .clk(clk), .rst_n(rst_n), .start(shift && at_first),
      .fin(shift && at_last), .valid(ae_valid)
   );

   ofsl_validgen #(.DLY(AF_DLY)) u_af_v (
      .clk(clk), .rst_n(rst_n), .start(shift && at_first),
      .fin(shift && at_last), .valid(af_valid)
   );

endmodule

// File: rtl/serial_offset_loader_chk.sv
module serial_offset_loader_chk #(
   parameter int OFS_W = 10,
   parameter int AE_DLY = 2,
   parameter int AF_DLY = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load_n,
   input logic             sen_n,
   input logic [OFS_W-1:0] ae_ofs,
   input logic [OFS_W-1:0] af_ofs,
   input logic             ae_valid,
   input logic             af_valid,
   input logic             set_done
);

   // Cycles since the last ready pulse, saturating.
   logic [15:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gap_q <= '1;
      else if (set_done)       gap_q <= '0;
      else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
   end

   // R4: no capture leaves both offsets untouched
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n || sen_n) |=> ($stable(ae_ofs) && $stable(af_ofs)));

   // R7: ready lasts a single cycle
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_done |=> !set_done);

   // R6: flags still invalid when the ready pulse appears
   p_invalid_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_done |-> (!ae_valid && !af_valid));

   // R6: validity only falls on an edge that captured a bit
   p_fall_on_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ae_valid) || $fell(af_valid)) |-> $past(!load_n && !sen_n));

   // R8: almost-full validity returns after its configured delay
   p_af_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(af_valid) |-> (gap_q == 16'(AF_DLY - 1)));

   // R8: almost-empty validity returns after its configured delay
   p_ae_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ae_valid) |-> (gap_q == 16'(AE_DLY - 1)));

endmodule

bind serial_offset_loader serial_offset_loader_chk #(
   .OFS_W(OFS_W), .AE_DLY(AE_DLY), .AF_DLY(AF_DLY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .load_n(load_n), .sen_n(sen_n),
   .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ae_valid(ae_valid),
   .af_valid(af_valid), .set_done(set_done)
);

// File: tb/serial_offset_loader_bench.sv
`timescale 1ns/1ps
module serial_offset_loader_bench;

   localparam int W = 10;
   localparam logic [W-1:0] D_AE = 10'd8;
   localparam logic [W-1:0] D_AF = 10'd16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic load_n = 1'b1;
   logic sen_n = 1'b1;
   logic sdi = 1'b0;
   logic [W-1:0] ae_ofs, af_ofs;
   logic ae_valid, af_valid, set_done;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   serial_offset_loader #(
      .OFS_W(W), .DEF_AE(D_AE), .DEF_AF(D_AF), .AE_DLY(2), .AF_DLY(2)
   ) u_serial_offset_loader (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .sen_n(sen_n), .sdi(sdi),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs), .ae_valid(ae_valid),
      .af_valid(af_valid), .set_done(set_done)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Drive for one rising edge, return at the following falling edge.
   task automatic step(input logic ln, input logic sn, input logic b);
      load_n = ln; sen_n = sn; sdi = b;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      check(ae_ofs == D_AE, "R1", "ae_ofs default", ae_ofs, D_AE);
      check(af_ofs == D_AF, "R1", "af_ofs default", af_ofs, D_AF);
      check(ae_valid && af_valid, "R1", "valids", {ae_valid, af_valid}, 2'b11);
      check(!set_done, "R1", "set_done", set_done, 0);
   endtask

   // pmode 0: continuous; 1: load low/sen high pauses; 2: load high; 3: both high
   task automatic t_load(input logic [W-1:0] ae, input logic [W-1:0] af,
                         input int pmode);
      logic [2*W-1:0] s;
      logic [W-1:0] ae_snap, af_snap;
      s = {af, ae};
      for (int k = 0; k < 2*W; k++) begin
         if (pmode != 0 && (k % 3) == 2) begin
            ae_snap = ae_ofs; af_snap = af_ofs;
            for (int p = 0; p < 3; p++) begin
               step(pmode == 1 ? 1'b0 : 1'b1, pmode == 2 ? 1'b0 : 1'b1, ~s[k]);
            end
            check(ae_ofs == ae_snap && af_ofs == af_snap, "R4",
                  "offsets during pause", {ae_ofs, af_ofs}, {ae_snap, af_snap});
         end
         step(1'b0, 1'b0, s[k]);
         if (k == 0) begin
            check(!ae_valid && !af_valid, "R6", "valids after first bit",
                  {ae_valid, af_valid}, 0);
         end
         if (k == W - 1) begin
            check(ae_ofs == ae, "R3", "ae_ofs mid-load", ae_ofs, ae);
         end
         if (k < 2*W - 1) begin
            check(!set_done, "R7", "no early done", set_done, 0);
         end
      end
      check(set_done, "R7", "done after last bit", set_done, 1);
      check(!ae_valid && !af_valid, "R6", "valids at done", {ae_valid, af_valid}, 0);
      step(1'b1, 1'b1, 1'b0);
      check(!set_done, "R7", "done one cycle", set_done, 0);
      check(!ae_valid && !af_valid, "R8", "valids one edge later",
            {ae_valid, af_valid}, 0);
      step(1'b1, 1'b1, 1'b0);
      check(ae_valid && af_valid, "R8", "valids two edges later",
            {ae_valid, af_valid}, 2'b11);
      check(ae_ofs == ae, "R3", "ae_ofs", ae_ofs, ae);
      check(af_ofs == af, "R5", "af_ofs after pauses", af_ofs, af);
   endtask

   task automatic t_no_shift_r4();
      logic [W-1:0] a0, f0;
      a0 = ae_ofs; f0 = af_ofs;
      for (int i = 0; i < 4; i++) step(1'b0, 1'b1, i[0]);
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, ~i[0]);
      check(ae_ofs == a0 && af_ofs == f0, "R4", "offsets with one enable",
            {ae_ofs, af_ofs}, {a0, f0});
      check(ae_valid && af_valid && !set_done, "R4", "flags untouched",
            {ae_valid, af_valid, set_done}, 3'b110);
   endtask

   task automatic t_reset_mid_r10();
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1);
      rst_n = 1'b0;
      step(1'b1, 1'b1, 1'b0);
      rst_n = 1'b1;
      step(1'b1, 1'b1, 1'b0);
      check(ae_ofs == D_AE && af_ofs == D_AF, "R10", "defaults after reset",
            {ae_ofs, af_ofs}, {D_AE, D_AF});
      check(ae_valid && af_valid, "R10", "valids after reset",
            {ae_valid, af_valid}, 2'b11);
      t_load(10'h2C9, 10'h133, 0);
   endtask

   initial begin
      #(4 * 200000);
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_load(10'h1A5, 10'h35C, 0);  // R2 R3
      t_no_shift_r4();
      t_load(10'h0F3, 10'h2A6, 1);  // R4 R5 pause: load low, sen high
      t_load(10'h3C1, 10'h05A, 2);  // R4 R5 pause: load high
      t_load(10'h15B, 10'h3E4, 3);  // R9 reload, pause: both high
      t_reset_mid_r10();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule